// File: doc/BRIEF.md
# Transactional Cache-Line Conflict Tracker

This block follows the read set and the write set of one hardware transaction at cache-line granularity. A begin command opens the transaction. Each local access then lands in a small table of tracked lines, and every line that has been written carries a speculative-write mark. The companion data buffer reads these marks so that it can hold those lines back from other agents. Incoming coherence snoops are compared with the table. A snoop causes a conflict when it hits a tracked line and at least one of the two accesses is a write. The conflict aborts the transaction straight away and does not wait for commit.

Evictions are reported to the block as single events. Evicting a line that holds a speculative-write mark aborts the transaction. Evicting a line that was only read does not abort. Instead, its line number is hashed into a small Bloom-style filter, so a later write snoop to that line is still caught, at the cost of occasional false conflicts. A commit releases every speculative write in one cycle. An abort drops every mark. In both cases the table and the filter are cleared.

Top module: `txn_conflict_tracker`

## Requirements
- R1: The line number is `addr >> LINE_OFF` (default 4). Addresses that differ only in their low LINE_OFF bits refer to the same tracked line.
- R2: An access to an untracked line takes the lowest-numbered free table entry. A write access sets bit i of `spec_wr_mask` for its entry i. The marks hold until a commit or an abort.
- R3: While a transaction is active, evicting a tracked line whose write mark is set raises an abort with cause 2.
- R4: Evicting a tracked line that was only read does not abort. The entry is freed, and two filter bits are set. Bit A is the low 4 bits of the line number. Bit B is the XOR of the remaining 4-bit chunks of the line number (line[7:4] ^ line[11:8] by default).
- R5: A snoop that hits a tracked line aborts with cause 1 when the snoop is a write or the line is write-marked. A read snoop that hits a read-only line, and any snoop that hits nothing, has no effect.
- R6: A write snoop whose line finds both of its filter bits set (A and B, computed as in R4) aborts with cause 1, even when the match is a false positive. A read snoop never conflicts through the filter.
- R7: An abort shows as a one-cycle `abort_pulse` in the cycle after its cause, with `abort_cause` valid. In that same cycle `active` is low and `spec_wr_mask` is zero.
- R8: A commit gives a one-cycle `commit_pulse`. During that pulse `commit_mask` equals the write marks from just before the commit, and `active` and `spec_wr_mask` are already clear.
- R9: The overflow filter is empty after every begin, commit and abort.
- R10: An access to an untracked line when all entries are in use aborts with cause 3. An access to a line that is already tracked does not.
- R11: An explicit abort command aborts with cause 0. When several causes arise in one cycle, the order is explicit (0), then conflict (1), then eviction (2), then capacity (3). Any abort beats a commit in the same cycle, and a commit drops any access in its own cycle.
- R12: A begin while active is ignored. A commit or an abort command while idle is ignored. Accesses, snoops and evictions while idle are not tracked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_begin | input | 1 | Open a transaction |
| tx_commit | input | 1 | Commit the open transaction |
| tx_abort_req | input | 1 | Explicit abort command |
| acc_valid | input | 1 | Local access event |
| acc_addr | input | ADDR_W | Physical address of the access |
| acc_write | input | 1 | 1 = write access, 0 = read |
| snp_valid | input | 1 | Snoop event |
| snp_addr | input | ADDR_W | Snoop physical address |
| snp_write | input | 1 | 1 = write (ownership) snoop |
| evict_valid | input | 1 | Eviction event |
| evict_addr | input | ADDR_W | Address of the evicted line |
| active | output | 1 | A transaction is open |
| abort_pulse | output | 1 | One-cycle abort indication |
| abort_cause | output | 2 | 0 explicit, 1 conflict, 2 write-set eviction, 3 capacity |
| commit_pulse | output | 1 | One-cycle commit indication |
| commit_mask | output | ENTRIES | Write marks released by the commit |
| spec_wr_mask | output | ENTRIES | Speculative-write mark per table entry |

## Verification
The hardest situation to reach is a conflict that exists only through the filter. To get there, the bench makes a read-only line leave the table through an eviction and then sends a write snoop whose hashes collide with that line. The bench reaches this state by reading and evicting one fixed line in a fresh transaction. It then sweeps write snoops over 64 line numbers and predicts, from the two hash formulas, which of them must abort. Priority between causes that arrive in the same cycle is tested by driving two causes together.

// File: rtl/txn_conflict_tracker.sv
module txn_conflict_tracker #(
  parameter int ADDR_W   = 16,
  parameter int LINE_OFF = 4,
  parameter int ENTRIES  = 4,
  parameter int FILT_IDX = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tx_begin,
  input  logic               tx_commit,
  input  logic               tx_abort_req,
  input  logic               acc_valid,
  input  logic [ADDR_W-1:0]  acc_addr,
  input  logic               acc_write,
  input  logic               snp_valid,
  input  logic [ADDR_W-1:0]  snp_addr,
  input  logic               snp_write,
  input  logic               evict_valid,
  input  logic [ADDR_W-1:0]  evict_addr,
  output logic               active,
  output logic               abort_pulse,
  output logic [1:0]         abort_cause,
  output logic               commit_pulse,
  output logic [ENTRIES-1:0] commit_mask,
  output logic [ENTRIES-1:0] spec_wr_mask
);
  localparam int LINE_W    = ADDR_W - LINE_OFF;
  localparam int FILT_BITS = 1 << FILT_IDX;
  localparam int CHUNKS    = (LINE_W + FILT_IDX - 1) / FILT_IDX;

  logic [ENTRIES-1:0]   ent_vld, ent_rd, ent_wr;
  logic [LINE_W-1:0]    ent_tag [ENTRIES];
  logic [FILT_BITS-1:0] filt;

  function automatic logic [FILT_IDX-1:0] hash_a(input logic [LINE_W-1:0] ln);
    return ln[FILT_IDX-1:0];
  endfunction

  function automatic logic [FILT_IDX-1:0] hash_b(input logic [LINE_W-1:0] ln);
    logic [FILT_IDX-1:0] h = '0;
    for (int c = 1; c < CHUNKS; c++) h ^= FILT_IDX'(ln >> (c * FILT_IDX));
    return h;
  endfunction

  wire [LINE_W-1:0] acc_line = acc_addr[ADDR_W-1:LINE_OFF];
  wire [LINE_W-1:0] snp_line = snp_addr[ADDR_W-1:LINE_OFF];
  wire [LINE_W-1:0] ev_line  = evict_addr[ADDR_W-1:LINE_OFF];

  logic [ENTRIES-1:0] acc_hit, snp_hit, ev_hit;
  logic               has_free;
  logic [$clog2(ENTRIES+1)-1:0] free_idx;

  always_comb begin
    has_free = 1'b0;
    free_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      acc_hit[i] = ent_vld[i] && ent_tag[i] == acc_line;
      snp_hit[i] = ent_vld[i] && ent_tag[i] == snp_line;
      ev_hit[i]  = ent_vld[i] && ent_tag[i] == ev_line;
    end
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (!ent_vld[i]) begin
        has_free = 1'b1;
        free_idx = ($clog2(ENTRIES+1))'(i);
      end
  end

  wire filt_hit  = filt[hash_a(snp_line)] && filt[hash_b(snp_line)];
  wire tbl_conf  = |(snp_hit & (snp_write ? (ent_rd | ent_wr) : ent_wr));
  wire conflict  = snp_valid && (tbl_conf || (snp_write && filt_hit));
  wire ev_wr     = evict_valid && |(ev_hit & ent_wr);
  wire ev_rd     = evict_valid && |ev_hit && !ev_wr;
  wire cap_fail  = acc_valid && !(|acc_hit) && !has_free;
  wire any_abort = tx_abort_req || conflict || ev_wr || cap_fail;

  assign spec_wr_mask = ent_wr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active       <= 1'b0;
      abort_pulse  <= 1'b0;
      abort_cause  <= 2'd0;
      commit_pulse <= 1'b0;
      commit_mask  <= '0;
      ent_vld      <= '0;
      ent_rd       <= '0;
      ent_wr       <= '0;
      filt         <= '0;
      for (int i = 0; i < ENTRIES; i++) ent_tag[i] <= '0;
    end else begin
      abort_pulse  <= 1'b0;
      commit_pulse <= 1'b0;
      commit_mask  <= '0;
      if (!active) begin
        if (tx_begin) begin
          active  <= 1'b1;
          ent_vld <= '0;
          ent_rd  <= '0;
          ent_wr  <= '0;
          filt    <= '0;
        end
      end else if (any_abort) begin
        abort_pulse <= 1'b1;
        abort_cause <= tx_abort_req ? 2'd0 : conflict ? 2'd1 : ev_wr ? 2'd2 : 2'd3;
        active  <= 1'b0;
        ent_vld <= '0;
        ent_rd  <= '0;
        ent_wr  <= '0;
        filt    <= '0;
      end else if (tx_commit) begin
        commit_pulse <= 1'b1;
        commit_mask  <= ent_wr;
        active  <= 1'b0;
        ent_vld <= '0;
        ent_rd  <= '0;
        ent_wr  <= '0;
        filt    <= '0;
      end else begin
        if (acc_valid) begin
          if (|acc_hit) begin
            for (int i = 0; i < ENTRIES; i++)
              if (acc_hit[i]) begin
                if (acc_write) ent_wr[i] <= 1'b1;
                else           ent_rd[i] <= 1'b1;
              end
          end else begin
            for (int i = 0; i < ENTRIES; i++)
              if (free_idx == ($clog2(ENTRIES+1))'(i)) begin
                ent_vld[i] <= 1'b1;
                ent_tag[i] <= acc_line;
                ent_rd[i]  <= !acc_write;
                ent_wr[i]  <= acc_write;
              end
          end
        end
        if (ev_rd) begin
          for (int i = 0; i < ENTRIES; i++)
            if (ev_hit[i]) begin
              ent_vld[i] <= 1'b0;
              ent_rd[i]  <= 1'b0;
            end
          filt[hash_a(ev_line)] <= 1'b1;
          filt[hash_b(ev_line)] <= 1'b1;
        end
      end
    end
  end

  assert_abort_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    abort_pulse |-> (!active && spec_wr_mask == '0 && $past(active)));
  assert_evict_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_pulse && abort_cause == 2'd2) |-> $past(evict_valid));
  assert_conflict_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_pulse && abort_cause == 2'd1) |-> $past(snp_valid));
  assert_capacity_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_pulse && abort_cause == 2'd3) |-> ($past(acc_valid) && $past(&ent_vld)));
  assert_commit_once_R8: assert property (@(posedge clk) disable iff (!rst_n)
    commit_pulse |-> (!active && !abort_pulse && $past(tx_commit) && $past(active)));
  assert_filter_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_pulse || commit_pulse || $rose(active)) |-> filt == '0);
  assert_begin_only_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> $past(tx_begin));
endmodule

// File: tb/tb_txn_conflict_tracker.sv
module tb_txn_conflict_tracker;
  localparam int AW = 16;
  localparam int NE = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tx_begin = 0, tx_commit = 0, tx_abort_req = 0;
  logic acc_valid = 0, acc_write = 0, snp_valid = 0, snp_write = 0, evict_valid = 0;
  logic [AW-1:0] acc_addr = '0, snp_addr = '0, evict_addr = '0;
  logic active, abort_pulse, commit_pulse;
  logic [1:0] abort_cause;
  logic [NE-1:0] commit_mask, spec_wr_mask;

  int tests = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  txn_conflict_tracker dut (
    .clk(clk), .rst_n(rst_n), .tx_begin(tx_begin), .tx_commit(tx_commit),
    .tx_abort_req(tx_abort_req), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .acc_write(acc_write), .snp_valid(snp_valid), .snp_addr(snp_addr),
    .snp_write(snp_write), .evict_valid(evict_valid), .evict_addr(evict_addr),
    .active(active), .abort_pulse(abort_pulse), .abort_cause(abort_cause),
    .commit_pulse(commit_pulse), .commit_mask(commit_mask), .spec_wr_mask(spec_wr_mask));

  function automatic logic [AW-1:0] ad(input int ln, input int off);
    return AW'((ln << 4) | (off & 15));
  endfunction

  function automatic bit in_filter(input int ln, input int ref_ln);
    int ra = ref_ln & 15, rb = ((ref_ln >> 4) ^ (ref_ln >> 8)) & 15;
    int ta = ln & 15,     tb = ((ln >> 4) ^ (ln >> 8)) & 15;
    return (ta == ra || ta == rb) && (tb == ra || tb == rb);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    tx_begin = 0; tx_commit = 0; tx_abort_req = 0;
    acc_valid = 0; snp_valid = 0; evict_valid = 0;
  endtask

  task automatic do_begin();  tx_begin = 1; tick(); endtask
  task automatic do_commit(); tx_commit = 1; tick(); endtask
  task automatic do_abort();  tx_abort_req = 1; tick(); endtask
  task automatic do_acc(input int ln, input int off, input bit w);
    acc_valid = 1; acc_addr = ad(ln, off); acc_write = w; tick();
  endtask
  task automatic do_snp(input int ln, input int off, input bit w);
    snp_valid = 1; snp_addr = ad(ln, off); snp_write = w; tick();
  endtask
  task automatic do_evict(input int ln, input int off);
    evict_valid = 1; evict_addr = ad(ln, off); tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R12 reset active", active, 0);
    chk("R7 reset abort", abort_pulse, 0);
    chk("R2 reset marks", spec_wr_mask, 0);

    // R12: idle commands and events have no effect
    do_commit();
    chk("R12 idle commit", commit_pulse, 0);
    do_abort();
    chk("R12 idle abort", abort_pulse, 0);
    do_acc(5, 0, 1);
    chk("R12 idle access", spec_wr_mask, 0);
    do_begin();
    chk("R12 begin", active, 1);
    chk("R12 idle access not tracked", spec_wr_mask, 0);

    // R1/R2: offsets fold into one line, lowest free entry
    do_acc(16, 0, 0);
    do_acc(17, 2, 1);
    chk("R2 second entry marked", spec_wr_mask, 2);
    do_acc(17, 9, 1);
    do_acc(18, 0, 1);
    chk("R1 offset folded", spec_wr_mask, 6);
    do_begin();
    chk("R12 begin while active", spec_wr_mask, 6);
    do_snp(40, 0, 0);
    chk("R5 snoop miss", abort_pulse, 0);
    do_snp(16, 3, 0);
    chk("R5 read-read no conflict", abort_pulse, 0);
    do_acc(19, 0, 0);
    chk("R10 fourth entry no abort", abort_pulse, 0);
    do_acc(17, 5, 0);
    chk("R10 tracked line at full", abort_pulse, 0);
    do_acc(20, 0, 0);
    chk("R10 capacity abort", abort_pulse, 1);
    chk("R10 capacity cause", abort_cause, 3);
    chk("R7 marks cleared", spec_wr_mask, 0);
    chk("R7 inactive", active, 0);

    // R5 sweep: snoop kind x line state
    for (int sw = 0; sw < 2; sw++)
      for (int lw = 0; lw < 2; lw++) begin
        do_begin();
        do_acc(16, 0, bit'(lw));
        do_snp(16, 7, bit'(sw));
        chk("R5 conflict rule", abort_pulse, sw | lw);
        if (sw | lw) chk("R5 cause", abort_cause, 1);
        else begin
          do_abort();
          chk("R11 explicit cause", abort_cause, 0);
        end
      end

    // R3: eviction of written line
    do_begin();
    do_acc(33, 0, 1);
    do_evict(60, 0);
    chk("R3 untracked eviction", abort_pulse, 0);
    do_evict(33, 4);
    chk("R3 write eviction abort", abort_pulse, 1);
    chk("R3 cause", abort_cause, 2);

    // R4/R6: eviction of read-only line feeds the filter, sweep snoops
    for (int t = 0; t < 64; t++) begin
      do_begin();
      do_acc(16'h125, 0, 0);
      do_evict(16'h125, 3);
      if (t == 0) begin
        chk("R4 read eviction no abort", abort_pulse, 0);
        chk("R4 still active", active, 1);
        do_snp(16'h125, 0, 0);
        chk("R6 read snoop via filter", abort_pulse, 0);
        do_snp(16'h125, 0, 1);
        chk("R6 write snoop after spill", abort_pulse, 1);
        do_begin();
        do_acc(16'h125, 0, 0);
        do_evict(16'h125, 3);
      end
      do_snp(t, 1, 1);
      chk("R6 filter sweep", abort_pulse, int'(in_filter(t, 16'h125)));
      if (!abort_pulse) do_abort();
    end

    // R9: filter emptied by commit
    do_begin();
    do_acc(16'h125, 0, 0);
    do_evict(16'h125, 0);
    do_commit();
    do_begin();
    do_snp(16'h125, 0, 1);
    chk("R9 filter cleared", abort_pulse, 0);
    do_abort();

    // R8: commit releases marks together
    do_begin();
    do_acc(50, 0, 1);
    do_acc(51, 0, 0);
    do_acc(52, 0, 1);
    do_commit();
    chk("R8 commit pulse", commit_pulse, 1);
    chk("R8 commit mask", commit_mask, 5);
    chk("R8 marks cleared", spec_wr_mask, 0);
    chk("R8 inactive", active, 0);
    tick();
    chk("R8 single pulse", commit_pulse, 0);

    // R11: priority
    do_begin();
    do_acc(70, 0, 1);
    tx_abort_req = 1; snp_valid = 1; snp_addr = ad(70, 0); snp_write = 1; tick();
    chk("R11 explicit over conflict", abort_cause, 0);
    do_begin();
    do_acc(70, 0, 1);
    snp_valid = 1; snp_addr = ad(70, 0); snp_write = 0;
    evict_valid = 1; evict_addr = ad(70, 0); tick();
    chk("R11 conflict over eviction", abort_cause, 1);
    do_begin();
    do_acc(70, 0, 1);
    tx_commit = 1; snp_valid = 1; snp_addr = ad(70, 0); snp_write = 0; tick();
    chk("R11 abort beats commit", abort_pulse, 1);
    chk("R11 no commit pulse", commit_pulse, 0);
    do_begin();
    tx_commit = 1; acc_valid = 1; acc_addr = ad(71, 0); acc_write = 1; tick();
    chk("R11 commit drops access", commit_mask, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule